// File: doc/BRIEF.md
# Power Change Interrupt Generator

This block lives inside the register file of a storage host controller. It watches CPU writes to three control registers: bus power, host control 2 and software reset. It raises an interrupt only when a write really changes the IO bus power or the IO signalling voltage. A write that leaves the watched bit as it was raises nothing. Each kind of change sets its own sticky status bit: bus went on, bus went off, signalling dropped to low voltage, or signalling returned to high voltage. A status bit stays set until software acknowledges it.

All registers share one word-wide write port with byte enables. Word 0 packs four byte lanes: bus power (lane 0), software reset (lane 1), host control 2 low byte (lane 2) and acknowledge (lane 3). Because of this packing, one write can carry both an event and its acknowledge. Word 1 lane 0 holds the interrupt mask. The interrupt line is the OR of status AND mask. The block also shows the tracked bus-power state and the tracked 1.8 V select state. The voltage regulators and the card interface are outside it.

Top module: `pwrirq_gen`

## Requirements
- R1: After reset, all status bits are 0, the mask is 0, `irq` is 0, `bus_on` is 0 and `io_18v` is 0 (3.3 V signalling).
- R2: A write to word 0 with lane 0 enabled that changes bit 0 (data bit 0) sets status bit 0 (bus-on) when the bit goes 0 to 1. It sets status bit 1 (bus-off) when the bit goes 1 to 0. The status bit is set on the clock edge that captures the write.
- R3: A write to word 0 with lane 2 enabled that changes bit 3 of that lane (data bit 19) sets status bit 2 (IO-low) when the 1.8 V select becomes 1. It sets status bit 3 (IO-high) when the select becomes 0.
- R4: A write that leaves the watched power bit or 1.8 V select bit unchanged sets no status bit. This includes writing 0 to the 1.8 V select straight after reset.
- R5: Writing 1 to bit 1 of lane 1 (data bit 9) is a full software reset. If bus power is on, it sets status bit 1 and `bus_on` becomes 0. If bus power is already off, it sets nothing.
- R6: When one write carries a full software reset and a lane 0 power write together, the reset wins and the power write is discarded.
- R7: Writing 1 to lane 3 bit 0 (data bit 24) clears status bits 0 and 1. Writing 1 to lane 3 bit 1 (data bit 25) clears status bits 2 and 3. Other status bits are kept.
- R8: If an event and the acknowledge that would clear its status bit arrive in the same write, the status bit ends up set.
- R9: Bits 3:0 of word 1 lane 0 form the mask. `irq` equals the OR of status AND mask, and it follows a status or mask change in the same cycle the register changes.
- R10: A write is ignored when `wr_en` is 0, when the byte lane is not enabled, or when the word address is neither 0 nor 1.
- R11: `bus_on` and `io_18v` show the tracked power and 1.8 V select states. They update on the edge that captures the changing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | BUS_W | Write data |
| wr_be | input | BUS_W/8 | Byte-lane enables |
| irq | output | 1 | Power change interrupt |
| evt_status | output | 4 | Sticky status: bus-on, bus-off, IO-low, IO-high |
| bus_on | output | 1 | Tracked bus power state |
| io_18v | output | 1 | Tracked 1.8 V signalling select |

## Verification
The bench builds the block with its default 32-bit data word and 4-bit word address. These are the smallest values that fit all four control lanes in one word. That lets a single write combine a reset with a power write, or an event with its acknowledge, and it exposes unused addresses 2 to 15 for the ignore cases. With the mask fully open or partly closed, every status bit can be seen on `irq`. A random phase mixes lanes and addresses, so it reaches both the unchanged-bit writes and the same-cycle conflicts many times.

// File: rtl/pwrirq_pkg.sv
package pwrirq_pkg;

    localparam int LANE_W     = 8;
    localparam int NUM_EVT    = 4;

    // byte lanes inside the control word; bit positions within a lane
    localparam int LANE_PWR   = 0;
    localparam int LANE_RST   = 1;
    localparam int LANE_HC2   = 2;
    localparam int LANE_ACK   = 3;
    localparam int LANE_MASK  = 0;

    localparam int BIT_PWR     = 0;
    localparam int BIT_RST_ALL = 1;
    localparam int BIT_V18     = 3;
    localparam int BIT_ACK_BUS = 0;
    localparam int BIT_ACK_IO  = 1;

    localparam int WORD_CTRL  = 0;
    localparam int WORD_MASK  = 1;

    typedef enum int {
        EV_BUS_ON  = 0,
        EV_BUS_OFF = 1,
        EV_IO_LOW  = 2,
        EV_IO_HIGH = 3
    } evt_idx_e;

    typedef struct packed {
        logic               pwr_wr;
        logic               pwr_val;
        logic               rst_all;
        logic               hc2_wr;
        logic               v18_val;
        logic [NUM_EVT-1:0] ack_clr;
        logic               mask_wr;
        logic [NUM_EVT-1:0] mask_val;
    } wr_req_t;

    typedef struct packed {
        logic bus;
        logic v18;
    } trk_state_t;

    typedef struct packed {
        logic [NUM_EVT-1:0] stat;
        logic [NUM_EVT-1:0] mask;
    } stat_state_t;

endpackage

// File: rtl/pwrirq_decode.sv
module pwrirq_decode
    import pwrirq_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic [BUS_W/8-1:0] wr_be,
    output wr_req_t            req
);

    localparam int NUM_LANES = BUS_W / LANE_W;

    logic [NUM_LANES-1:0][LANE_W-1:0] lane;
    logic                             ctrl_hit;
    logic                             mask_hit;
    logic                             unused_bits;

    assign lane        = wr_data;
    assign ctrl_hit    = wr_en && (wr_addr == ADDR_W'(WORD_CTRL));
    assign mask_hit    = wr_en && (wr_addr == ADDR_W'(WORD_MASK));
    assign unused_bits = ^wr_data;

    always_comb begin
        req          = '0;
        req.rst_all  = ctrl_hit && wr_be[LANE_RST] && lane[LANE_RST][BIT_RST_ALL];
        req.pwr_wr   = ctrl_hit && wr_be[LANE_PWR];
        req.pwr_val  = lane[LANE_PWR][BIT_PWR];
        req.hc2_wr   = ctrl_hit && wr_be[LANE_HC2];
        req.v18_val  = lane[LANE_HC2][BIT_V18];
        if (ctrl_hit && wr_be[LANE_ACK]) begin
            if (lane[LANE_ACK][BIT_ACK_BUS]) begin
                req.ack_clr[EV_BUS_ON]  = 1'b1;
                req.ack_clr[EV_BUS_OFF] = 1'b1;
            end
            if (lane[LANE_ACK][BIT_ACK_IO]) begin
                req.ack_clr[EV_IO_LOW]  = 1'b1;
                req.ack_clr[EV_IO_HIGH] = 1'b1;
            end
        end
        req.mask_wr  = mask_hit && wr_be[LANE_MASK];
        req.mask_val = lane[LANE_MASK][NUM_EVT-1:0];
    end

endmodule

// File: rtl/pwrirq_track.sv
module pwrirq_track
    import pwrirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  wr_req_t            req,
    output logic [NUM_EVT-1:0] evt_set,
    output logic               bus_on,
    output logic               io_18v
);

    trk_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        evt_set = '0;
        // a full reset overrides any power write riding in the same word
        if (req.rst_all) begin
            if (st_q.bus) begin
                evt_set[EV_BUS_OFF] = 1'b1;
                st_d.bus            = 1'b0;
            end
        end else if (req.pwr_wr && (req.pwr_val != st_q.bus)) begin
            if (req.pwr_val) evt_set[EV_BUS_ON]  = 1'b1;
            else             evt_set[EV_BUS_OFF] = 1'b1;
            st_d.bus = req.pwr_val;
        end
        if (req.hc2_wr && (req.v18_val != st_q.v18)) begin
            if (req.v18_val) evt_set[EV_IO_LOW]  = 1'b1;
            else             evt_set[EV_IO_HIGH] = 1'b1;
            st_d.v18 = req.v18_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_on = st_q.bus;
    assign io_18v = st_q.v18;

endmodule

// File: rtl/pwrirq_status.sv
module pwrirq_status
    import pwrirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_set,
    input  logic [NUM_EVT-1:0] ack_clr,
    input  logic               mask_wr,
    input  logic [NUM_EVT-1:0] mask_val,
    output logic [NUM_EVT-1:0] status,
    output logic               irq
);

    stat_state_t        ss_d, ss_q;
    logic [NUM_EVT-1:0] stat_nxt;

    // set beats clear, so a fresh event survives its own acknowledge
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        assign stat_nxt[i] = evt_set[i] | (ss_q.stat[i] & ~ack_clr[i]);
    end

    always_comb begin
        ss_d      = ss_q;
        ss_d.stat = stat_nxt;
        if (mask_wr) ss_d.mask = mask_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ss_q <= '0;
        else        ss_q <= ss_d;
    end

    assign status = ss_q.stat;
    assign irq    = |(ss_q.stat & ss_q.mask);

endmodule

// File: rtl/pwrirq_gen.sv
module pwrirq_gen
    import pwrirq_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic [BUS_W/8-1:0] wr_be,
    output logic               irq,
    output logic [3:0]         evt_status,
    output logic               bus_on,
    output logic               io_18v
);

    wr_req_t            req;
    logic [NUM_EVT-1:0] evt_set;

    pwrirq_decode #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_be   (wr_be),
        .req     (req)
    );

    pwrirq_track u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .evt_set (evt_set),
        .bus_on  (bus_on),
        .io_18v  (io_18v)
    );

    pwrirq_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_set),
        .ack_clr  (req.ack_clr),
        .mask_wr  (req.mask_wr),
        .mask_val (req.mask_val),
        .status   (evt_status),
        .irq      (irq)
    );

endmodule

// File: rtl/pwrirq_chk.sv
module pwrirq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       irq,
    input logic [3:0] evt_status,
    input logic       bus_on,
    input logic       io_18v
);

    p_bus_on_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_on) |-> evt_status[0]);

    p_bus_off_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_on) |-> evt_status[1]);

    p_io_low_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_18v) |-> evt_status[2]);

    p_io_high_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_18v) |-> evt_status[3]);

    p_quiet_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(bus_on) && $stable(io_18v) && $stable(evt_status)));

    p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (evt_status != 4'b0000));

endmodule

bind pwrirq_gen pwrirq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .irq        (irq),
    .evt_status (evt_status),
    .bus_on     (bus_on),
    .io_18v     (io_18v)
);

// File: tb/tb_pwrirq_gen.sv
`timescale 1ns/1ps
module tb_pwrirq_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        irq;
    logic [3:0]  evt_status;
    logic        bus_on;
    logic        io_18v;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwrirq_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .irq(irq),
        .evt_status(evt_status), .bus_on(bus_on), .io_18v(io_18v)
    );

    // behavioural reference model
    logic       m_bus, m_v18;
    logic [3:0] m_stat, m_mask;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_bus <= 0; m_v18 <= 0; m_stat <= 0; m_mask <= 0;
        end else begin
            logic [3:0] s_set, s_clr;
            s_set = 0; s_clr = 0;
            if (wr_en && wr_addr == 0) begin
                if (wr_be[1] && wr_data[9]) begin
                    if (m_bus) begin s_set[1] = 1; m_bus <= 0; end
                end else if (wr_be[0] && wr_data[0] != m_bus) begin
                    if (wr_data[0]) s_set[0] = 1; else s_set[1] = 1;
                    m_bus <= wr_data[0];
                end
                if (wr_be[2] && wr_data[19] != m_v18) begin
                    if (wr_data[19]) s_set[2] = 1; else s_set[3] = 1;
                    m_v18 <= wr_data[19];
                end
                if (wr_be[3] && wr_data[24]) s_clr = s_clr | 4'b0011;
                if (wr_be[3] && wr_data[25]) s_clr = s_clr | 4'b1100;
            end else if (wr_en && wr_addr == 1 && wr_be[0]) begin
                m_mask <= wr_data[3:0];
            end
            m_stat <= (m_stat & ~s_clr) | s_set;
        end
    end

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // model comparison on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done)
            check(cur_req, {irq, bus_on, io_18v, 1'b0, evt_status},
                  {|(m_stat & m_mask), m_bus, m_v18, 1'b0, m_stat});
    end

    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_be = 0; wr_data = 0;
    endtask

    task automatic ack_all();
        wr(0, 4'b1000, 32'h0300_0000);
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        check("R1 status", {4'b0, evt_status}, 8'h00);
        check("R1 irq/bus/io", {5'b0, irq, bus_on, io_18v}, 8'h00);

        cur_req = "R4";
        wr(0, 4'b0100, 32'h0000_0000);
        check("R4 hc2 zero after reset", {4'b0, evt_status}, 8'h00);
        cur_req = "R10";
        wr(0, 4'b1110, 32'h0000_0001);
        check("R10 lane0 disabled", {7'b0, bus_on}, 8'h00);
        wr(2, 4'b1111, 32'h0008_0201);
        check("R10 other address", {3'b0, bus_on, evt_status}, 8'h00);
        wr(1, 4'b1110, 32'h0000_000F);
        @(negedge clk);
        cur_req = "R9";
        wr(1, 4'b0001, 32'h0000_000F);

        cur_req = "R2";
        wr(0, 4'b0001, 32'h0000_0001);
        check("R2 bus on", {2'b0, irq, bus_on, evt_status}, 8'h31);
        cur_req = "R11";
        check("R11 bus_on view", {7'b0, bus_on}, 8'h01);
        cur_req = "R7";
        ack_all();
        cur_req = "R4";
        wr(0, 4'b0001, 32'h0000_0001);
        check("R4 bus unchanged", {3'b0, irq, evt_status}, 8'h00);

        cur_req = "R3";
        wr(0, 4'b0100, 32'h0008_0000);
        check("R3 io low", {2'b0, irq, io_18v, evt_status}, 8'h34);
        cur_req = "R7";
        wr(0, 4'b1000, 32'h0100_0000);
        check("R7 bus ack keeps io", {4'b0, evt_status}, 8'h04);
        cur_req = "R3";
        wr(0, 4'b0100, 32'h0000_0000);
        check("R3 io high", {3'b0, io_18v, evt_status}, 8'h0C);
        cur_req = "R7";
        wr(0, 4'b1000, 32'h0200_0000);
        check("R7 io ack", {4'b0, evt_status}, 8'h00);

        cur_req = "R8";
        wr(0, 4'b1001, 32'h0100_0000);
        check("R8 event beats ack", {3'b0, bus_on, evt_status}, 8'h02);
        cur_req = "R9";
        wr(1, 4'b0001, 32'h0000_0004);
        check("R9 masked off", {7'b0, irq}, 8'h00);
        wr(1, 4'b0001, 32'h0000_0002);
        check("R9 mask open", {7'b0, irq}, 8'h01);
        ack_all();
        check("R9 irq drops", {7'b0, irq}, 8'h00);
        wr(1, 4'b0001, 32'h0000_000F);

        cur_req = "R5";
        wr(0, 4'b0001, 32'h0000_0001);
        ack_all();
        wr(0, 4'b0010, 32'h0000_0200);
        check("R5 reset with bus on", {3'b0, bus_on, evt_status}, 8'h02);
        ack_all();
        wr(0, 4'b0010, 32'h0000_0200);
        check("R5 reset with bus off", {3'b0, bus_on, evt_status}, 8'h00);
        cur_req = "R6";
        wr(0, 4'b0011, 32'h0000_0201);
        check("R6 reset beats power write", {3'b0, bus_on, evt_status}, 8'h00);

        cur_req = "R10";
        @(negedge clk);
        wr_en = 0; wr_addr = 0; wr_be = 4'hF; wr_data = 32'h0008_0001;
        @(negedge clk);
        check("R10 wr_en low", {3'b0, bus_on, evt_status}, 8'h00);
        wr_be = 0; wr_data = 0;

        cur_req = "R2";
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] d;
            d = $urandom;
            @(negedge clk);
            wr_en   = ($urandom % 4) != 0;
            wr_addr = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 2);
            wr_be   = 4'($urandom);
            wr_data = d;
        end
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule